// File: doc/BRIEF.md
# Node Liveness Fault Monitor

This block gives one node of a three-dimensional torus network a view of which parties are alive. It watches two things. The first is the local host, whose software must send a refresh pulse at least once per programmable period. The second is the six directly linked neighbours, each of which must deliver a status message at least once per period. A party that stays silent for a whole period is marked faulty. A party that speaks again is marked healthy on the next clock edge.

The node's own view is packed into one status word. Bit 0 is the host's health, bit 1 is the local interface's health, and bits 2 to 7 hold one healthy bit per neighbour port. Port k maps to bit 2+k, in the order X+, X-, Y+, Y-, Z+, Z-. The word goes out on a single broadcast channel to all neighbours once per period as a heartbeat. It is also sent immediately whenever any bit changes, so fault news spreads across the torus without waiting for the next heartbeat. The monitor sits beside the data path and never stalls it.

Host software reads the local word and the last word heard from each neighbour through a small combinational read port. A one-cycle change pulse tells the host that the local word has just changed.

Top module: `liveness_monitor`

## Requirements
- R1: After reset the local word reads 0xFF (when the interface-health input is high), every stored neighbour word reads 0, tx_valid_o is low and change_o is low.
- R2: With a non-zero period P, the host bit (bit 0) drops at the P-th rising edge after the last refresh pulse or after the period was set. It is still high at edge P-1.
- R3: A refresh pulse sets the host bit back to 1 at the next edge and restarts the host timer.
- R4: Each neighbour port k has its own timer. If no status message arrives on that port for P edges, bit 2+k drops and the other bits are not affected.
- R5: A status message on port k sets bit 2+k back to 1 at the next edge and stores the received word, which is then readable at read address k+1.
- R6: With a non-zero period P, a heartbeat carrying the current word is sent every P edges (tx_valid_o high at edges P, 2P, ... after the period is set).
- R7: Whenever the local word changes, change_o is high for exactly the following cycle, and at the next edge a message carrying the new word is sent.
- R8: A period of zero disables all timeouts and heartbeats, and all timers are cleared.
- R9: Read address 0 returns the local word, addresses 1 to 6 return the stored neighbour words, and address 7 returns 0.
- R10: The interface bit (bit 1) follows if_ok_i with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 32 | Watchdog period in clock cycles; 0 disables |
| host_kick_i | input | 1 | Host refresh pulse |
| if_ok_i | input | 1 | Local interface health |
| rx_valid_i | input | 6 | Status message arriving, one bit per neighbour port |
| rx_word_i | input | 48 | Received status words, port k in bits 8k+7:8k |
| tx_valid_o | output | 1 | Broadcast status message valid |
| tx_word_o | output | 8 | Broadcast status word |
| change_o | output | 1 | One-cycle pulse when the local word changes |
| rd_addr_i | input | 3 | Host read address |
| rd_data_o | output | 8 | Host read data |

## Verification
On every cycle, the assertions check four things. A refresh or a received message restores the matching health bit. A health bit never drops while the period is zero. The host bit never drops in the cycle after a refresh. Every change pulse is followed by a transmitted message. Only the bench's scenarios can show the exact edge on which a timeout fires, the spacing of heartbeats, the order and content of the broadcast words when a heartbeat and a change message fall close together, and the read-port mapping.

// File: rtl/liveness_monitor.sv
module liveness_monitor #(
  parameter int NB = 6,
  parameter int CW = 32,
  localparam int W  = NB + 2,
  localparam int AW = $clog2(NB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     period_i,
  input  logic              host_kick_i,
  input  logic              if_ok_i,
  input  logic [NB-1:0]     rx_valid_i,
  input  logic [NB*W-1:0]   rx_word_i,
  output logic              tx_valid_o,
  output logic [W-1:0]      tx_word_o,
  output logic              change_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [W-1:0]      rd_data_o
);

  wire          en   = period_i != '0;
  wire [CW-1:0] last = period_i - 1'b1;

  logic          host_ok, if_q;
  logic [CW-1:0] hcnt, bcnt;
  logic [NB-1:0] nb_ok;
  logic [W-1:0]  nbw [NB];
  logic [W-1:0]  stat, stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt    <= '0;
      host_ok <= 1'b1;
    end else if (host_kick_i) begin
      hcnt    <= '0;
      host_ok <= 1'b1;
    end else if (!en) begin
      hcnt <= '0;
    end else if (host_ok) begin
      if (hcnt == last) host_ok <= 1'b0;
      else              hcnt    <= hcnt + 1'b1;
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_nb
    logic [CW-1:0] cnt;
    logic          ok;
    logic [W-1:0]  word;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        ok   <= 1'b1;
        word <= '0;
      end else if (rx_valid_i[k]) begin
        cnt  <= '0;
        ok   <= 1'b1;
        word <= rx_word_i[k*W +: W];
      end else if (!en) begin
        cnt <= '0;
      end else if (ok) begin
        if (cnt == last) ok  <= 1'b0;
        else             cnt <= cnt + 1'b1;
      end
    end
    assign nb_ok[k] = ok;
    assign nbw[k]   = word;
  end

  wire beat = en && (bcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt       <= '0;
      if_q       <= 1'b1;
      stat_q     <= '1;
      tx_valid_o <= 1'b0;
      tx_word_o  <= '0;
    end else begin
      bcnt       <= (!en || beat) ? '0 : bcnt + 1'b1;
      if_q       <= if_ok_i;
      stat_q     <= stat;
      tx_valid_o <= beat || change_o;
      tx_word_o  <= stat;
    end
  end

  assign stat     = {nb_ok, if_q, host_ok};
  assign change_o = stat != stat_q;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0) rd_data_o = stat;
    for (int k = 0; k < NB; k++)
      if (int'(rd_addr_i) == k + 1) rd_data_o = nbw[k];
  end

endmodule

module liveness_monitor_chk #(
  parameter int NB = 6,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] period_i,
  input logic          host_kick_i,
  input logic [NB-1:0] rx_valid_i,
  input logic          host_ok,
  input logic [NB-1:0] nb_ok,
  input logic          change_o,
  input logic          tx_valid_o
);

  AST_KICK_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    host_kick_i |=> host_ok); // R3

  AST_RX_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    |rx_valid_i |=> ((nb_ok & $past(rx_valid_i)) == $past(rx_valid_i))); // R5

  AST_NO_FALL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_ok) || ((~nb_ok & $past(nb_ok)) != '0)) |-> $past(period_i) != '0); // R8

  AST_NO_FALL_AFTER_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ok) |-> !$past(host_kick_i)); // R2

  AST_CHANGE_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |=> tx_valid_o); // R7

endmodule

bind liveness_monitor liveness_monitor_chk #(.NB(NB), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .period_i(period_i), .host_kick_i(host_kick_i),
  .rx_valid_i(rx_valid_i), .host_ok(host_ok), .nb_ok(nb_ok),
  .change_o(change_o), .tx_valid_o(tx_valid_o)
);

// File: tb/liveness_monitor_tb.sv
module liveness_monitor_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] period_i = 0;
  logic        host_kick_i = 0;
  logic        if_ok_i = 1;
  logic [5:0]  rx_valid_i = 0;
  logic [47:0] rx_word_i = 0;
  logic        tx_valid_o, change_o;
  logic [7:0]  tx_word_o, rd_data_o;
  logic [2:0]  rd_addr_i = 0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  liveness_monitor dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_tx(input logic [7:0] w);
    expq.push_back(w);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid_o) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6/R7 unexpected message actual=%0h expected=none", tx_word_o);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(tx_word_o == e, "R6/R7 tx word", tx_word_o, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    rd(0, d); chk(d == 8'hFF, "R1 local word", d, 8'hFF);
    rd(1, d); chk(d == 8'h00, "R1 neighbour word", d, 0);
    chk(tx_valid_o == 0, "R1 tx idle", tx_valid_o, 0);
    chk(change_o == 0, "R1 no change", change_o, 0);
    rd(7, d); chk(d == 8'h00, "R9 out of range", d, 0);

    // R8 zero period: no timeouts, no heartbeats
    tick(50);
    rd(0, d); chk(d == 8'hFF, "R8 no timeout", d, 8'hFF);
    chk(expq.size() == 0, "R8 no heartbeat", expq.size(), 0);

    // R10 / R7 interface bit and change pulse
    expect_tx(8'hFD);
    if_ok_i = 0;
    tick(1);
    rd(0, d); chk(d == 8'hFD, "R10 if bit follows", d, 8'hFD);
    chk(change_o == 1, "R7 change pulse", change_o, 1);
    tick(1);
    chk(change_o == 0, "R7 pulse one cycle", change_o, 0);
    expect_tx(8'hFF);
    if_ok_i = 1;
    tick(3);
    chk(expq.size() == 0, "R7 change messages sent", expq.size(), 0);

    // R2 / R3 host timeout and refresh, period 16, neighbours fed
    for (int k = 0; k < 6; k++) rx_word_i[k*8 +: 8] = 8'h10 + 8'(k);
    rx_valid_i = 6'h3F;
    expect_tx(8'hFF);
    expect_tx(8'hFE);
    period_i = 16;
    tick(15);
    rd(0, d); chk(d[0] == 1, "R2 host alive at P-1", d, 8'hFF);
    tick(1);
    rd(0, d); chk(d[0] == 0, "R2 host fault at P", d, 8'hFE);
    host_kick_i = 1;
    tick(1);
    host_kick_i = 0;
    expect_tx(8'hFF);
    rd(0, d); chk(d[0] == 1, "R3 host restored", d, 8'hFF);
    tick(1);
    period_i = 0;
    tick(3);
    chk(expq.size() == 0, "R2 messages sent", expq.size(), 0);
    for (int k = 0; k < 6; k++) begin
      rd(3'(k + 1), d); chk(d == 8'h10 + 8'(k), "R5/R9 stored word", d, 8'h10 + k);
    end

    // R6 heartbeat every 8 edges
    host_kick_i = 1;
    for (int k = 0; k < 4; k++) expect_tx(8'hFF);
    period_i = 8;
    tick(34);
    period_i = 0;
    tick(10);
    chk(expq.size() == 0, "R6 four heartbeats", expq.size(), 0);

    // R4 / R5 neighbour 2 timeout and recovery, period 10
    rx_valid_i = 6'h3B;
    expect_tx(8'hFF);
    expect_tx(8'hEF);
    period_i = 10;
    tick(9);
    rd(0, d); chk(d == 8'hFF, "R4 neighbour alive at P-1", d, 8'hFF);
    tick(1);
    rd(0, d); chk(d == 8'hEF, "R4 only bit 4 drops", d, 8'hEF);
    rx_word_i[2*8 +: 8] = 8'h5A;
    rx_valid_i = 6'h3F;
    expect_tx(8'hFF);
    tick(1);
    rd(0, d); chk(d == 8'hFF, "R5 neighbour restored", d, 8'hFF);
    rd(3, d); chk(d == 8'h5A, "R5 word stored", d, 8'h5A);
    tick(1);
    period_i = 0;
    host_kick_i = 0;
    rx_valid_i = 0;
    tick(40);
    rd(0, d); chk(d == 8'hFF, "R8 silence ignored", d, 8'hFF);
    chk(expq.size() == 0, "R4 messages sent", expq.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule